// File: doc/BRIEF.md
# Source Alignment Skew Shifter

This block lines up a stream of 16-bit source words with an arbitrary bit position in a destination word. It holds the two most recent source words in a 32-bit holding register. For each destination word step it returns the 16-bit window that starts a programmable number of bits (0 to 15) above bit 0 of that register. An upstream sequencer issues one step per destination word and marks the first and last step of each line. For each step the block fetches the source words it needs through a simple strobe handshake. It then presents the aligned word for one cycle.

The fill direction depends on the sign of the source walk. When the source is walked downward in memory, each new word enters the upper half of the register. When it is walked upward, each new word enters the lower half. Two flags in a small configuration register change how many words a line consumes. One adds a priming fetch at the start of each line. The other drops the closing fetch of a line unless the skew window still reaches into bits that the last-word mask leaves untouched.

Top module: `blit_align_shifter`

## Requirements
- R1: After synchronous reset, `busy`, `fetch_req` and `out_valid` are 0, `cfg_q` is 0x00, and the holding register is zero, so a step that fetches nothing returns 0x0000.
- R2: A write on `cfg_wr` stores `cfg_wdata & 8'hCF` in `cfg_q`. Bits 3:0 are the skew, bit 7 is the priming-fetch enable, bit 6 is the tail-suppress enable, and bits 5:4 always read 0.
- R3: The aligned word `out_word` equals bits 15:0 of the 32-bit holding register shifted right by the skew.
- R4: With `dir_neg`=0, every accepted source word shifts the holding register left by 16 bits, and the new word enters bits 15:0.
- R5: With `dir_neg`=1, every accepted source word shifts the holding register right by 16 bits, and the new word enters bits 31:16.
- R6: A step that fetches no word still shifts the holding register by 16 bits in the same direction and fills the vacated half with zeros.
- R7: A step with `step_first`=1 fetches two words when bit 7 is set, and one word otherwise.
- R8: A step with `step_last`=1 and `step_first`=0 fetches no word when bit 6 is set and `~(16'hFFFF >> skew)` is not greater than `last_mask` (unsigned). In every other non-first case it fetches one word.
- R9: A step with both `step_first` and `step_last` set follows R7 alone; tail suppression does not apply to it.
- R10: `fetch_req` is high only while the block waits for a word. The step stalls for as long as `src_valid` stays low, and `src_valid` has no effect while `fetch_req` is low.
- R11: `out_valid` is high for exactly one cycle per accepted step, and `busy` is low in the following cycle. `step_req` is taken only while `busy` is low.
- R12: A `blit_start` pulse clears the holding register to zero and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| blit_start | input | 1 | Start of a new blit; clears the holding register |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Stored configuration value |
| dir_neg | input | 1 | Source walks downward (negative x step) |
| last_mask | input | 16 | Mask of the last word of a line, used in the tail test |
| step_req | input | 1 | Request one aligned word |
| step_first | input | 1 | The requested step is the first of its line |
| step_last | input | 1 | The requested step is the last of its line |
| busy | output | 1 | A step is in progress |
| fetch_req | output | 1 | The block is waiting for a source word |
| src_valid | input | 1 | Source word strobe |
| src_data | input | 16 | Source word |
| out_valid | output | 1 | Aligned word valid (one cycle) |
| out_word | output | 16 | Aligned word |

## Verification
The hardest case to reach is the tail-suppression boundary. Here the skew-derived threshold equals or only just exceeds the last-word mask, so one value flips the step between zero and one fetches. This case only arises on a non-first step with bit 6 set. The bench sweeps every skew against mask values of 0x0000, 0x00FF, 0xF000 and 0xFFFF, in both directions, with every flag pair and line lengths of one to three words. This lands on the exact threshold (for example skew 4 against 0xF000). It also follows zero-fill steps with later windows, so a missing shift shows up in the next word.

// File: rtl/blit_align_pkg.sv
package blit_align_pkg;
  parameter int WORD_W    = 16;
  parameter int SKEW_W    = 4;
  parameter int CFG_W     = 8;
  parameter int HOLD_W    = 2 * WORD_W;
  parameter int EXTRA_BIT = 7;
  parameter int SUPP_BIT  = 6;
  parameter int NEED_W    = 2;

  parameter logic [CFG_W-1:0] CFG_KEEP =
    CFG_W'((1 << EXTRA_BIT) | (1 << SUPP_BIT) | ((1 << SKEW_W) - 1));

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HOLD_W-1:0] hold_t;
  typedef logic [SKEW_W-1:0] skew_t;
  typedef logic [NEED_W-1:0] need_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT} seq_state_t;

  // Push one word into the holding register in the given direction.
  function automatic hold_t hold_fill(hold_t cur, word_t w, logic neg);
    hold_t r;
    if (neg) r = {w, cur[HOLD_W-1:WORD_W]};
    else     r = {cur[WORD_W-1:0], w};
    return r;
  endfunction

  // Extract the aligned window.
  function automatic word_t align_window(hold_t cur, skew_t sk);
    hold_t sh;
    sh = cur >> sk;
    return sh[WORD_W-1:0];
  endfunction

  // Tail test: the skewed window still needs bits outside the last mask.
  function automatic logic tail_needs_fetch(skew_t sk, word_t mask);
    word_t ones;
    ones = '1;
    return (~(ones >> sk)) > mask;
  endfunction
endpackage

// File: rtl/blit_skew_cfg.sv
module blit_skew_cfg
  import blit_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q,
  output skew_t            skew,
  output logic             extra_en,
  output logic             supp_en
);
  logic [CFG_W-1:0] cfg_r;

  always_ff @(posedge clk) begin
    if (rst)     cfg_r <= '0;
    else if (wr) cfg_r <= wdata & CFG_KEEP;
  end

  assign q        = cfg_r;
  assign skew     = cfg_r[SKEW_W-1:0];
  assign extra_en = cfg_r[EXTRA_BIT];
  assign supp_en  = cfg_r[SUPP_BIT];
endmodule

// File: rtl/blit_fetch_plan.sv
module blit_fetch_plan
  import blit_align_pkg::*;
(
  input  logic  first,
  input  logic  last,
  input  logic  extra_en,
  input  logic  supp_en,
  input  skew_t skew,
  input  word_t last_mask,
  output need_t need
);
  logic tail_hit;

  assign tail_hit = tail_needs_fetch(skew, last_mask);

  always_comb begin
    if (first)                          need = extra_en ? need_t'(2) : need_t'(1);
    else if (last && supp_en && !tail_hit) need = need_t'(0);
    else                                need = need_t'(1);
  end
endmodule

// File: rtl/blit_hold_reg.sv
module blit_hold_reg
  import blit_align_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  load,
  input  logic  shift_empty,
  input  logic  neg,
  input  word_t data,
  output hold_t hold
);
  hold_t hold_r;
  word_t fill_word;

  assign fill_word = load ? data : '0;

  always_ff @(posedge clk) begin
    if (rst || clear)             hold_r <= '0;
    else if (load || shift_empty) hold_r <= hold_fill(hold_r, fill_word, neg);
  end

  assign hold = hold_r;
endmodule

// File: rtl/blit_align_shifter.sv
module blit_align_shifter
  import blit_align_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        blit_start,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_q,
  input  logic        dir_neg,
  input  logic [15:0] last_mask,
  input  logic        step_req,
  input  logic        step_first,
  input  logic        step_last,
  output logic        busy,
  output logic        fetch_req,
  input  logic        src_valid,
  input  logic [15:0] src_data,
  output logic        out_valid,
  output logic [15:0] out_word
);
  seq_state_t state_q;
  need_t      pending_q;
  need_t      need_cnt;
  skew_t      skew;
  logic       extra_en, supp_en;
  hold_t      hold_q;
  logic       accept_ev, load_ev, skip_ev;

  blit_skew_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .q(cfg_q), .skew(skew), .extra_en(extra_en), .supp_en(supp_en)
  );

  blit_fetch_plan u_plan (
    .first(step_first), .last(step_last), .extra_en(extra_en),
    .supp_en(supp_en), .skew(skew), .last_mask(last_mask), .need(need_cnt)
  );

  // Named events used by the sequencer and by the checker.
  assign accept_ev = (state_q == ST_IDLE) && step_req && !blit_start;
  assign load_ev   = (state_q == ST_FETCH) && src_valid && !blit_start;
  assign skip_ev   = accept_ev && (need_cnt == '0);

  blit_hold_reg u_hold (
    .clk(clk), .rst(rst), .clear(blit_start), .load(load_ev),
    .shift_empty(skip_ev), .neg(dir_neg), .data(src_data), .hold(hold_q)
  );

  always_ff @(posedge clk) begin
    if (rst || blit_start) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_ev) begin
          pending_q <= need_cnt;
          state_q   <= (need_cnt == '0) ? ST_EMIT : ST_FETCH;
        end
        ST_FETCH: if (load_ev) begin
          pending_q <= need_t'(pending_q - need_t'(1));
          if (pending_q == need_t'(1)) state_q <= ST_EMIT;
        end
        ST_EMIT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign fetch_req = (state_q == ST_FETCH);
  assign out_valid = (state_q == ST_EMIT);
  assign out_word  = align_window(hold_q, skew);
endmodule

// File: rtl/blit_align_checker.sv
module blit_align_checker
  import blit_align_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        blit_start,
  input logic        cfg_wr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_q,
  input logic        dir_neg,
  input logic        busy,
  input logic        fetch_req,
  input logic        out_valid,
  input logic [15:0] src_data,
  input hold_t       hold_q,
  input logic        load_ev,
  input logic        skip_ev
);
  p_cfg_mask_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_q == ($past(cfg_wdata) & CFG_KEEP));

  p_fill_pos_r4: assert property (@(posedge clk) disable iff (rst)
    (load_ev && !dir_neg) |=>
      (hold_q[15:0] == $past(src_data)) && (hold_q[31:16] == $past(hold_q[15:0])));

  p_fill_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (load_ev && dir_neg) |=>
      (hold_q[31:16] == $past(src_data)) && (hold_q[15:0] == $past(hold_q[31:16])));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (skip_ev && !dir_neg) |=> (hold_q[15:0] == 16'h0) && out_valid);

  p_fetch_busy_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> busy);

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid && !busy);

  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    blit_start |=> (hold_q == '0) && !busy);
endmodule

bind blit_align_shifter blit_align_checker u_chk (
  .clk(clk), .rst(rst), .blit_start(blit_start), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .dir_neg(dir_neg), .busy(busy),
  .fetch_req(fetch_req), .out_valid(out_valid), .src_data(src_data),
  .hold_q(hold_q), .load_ev(load_ev), .skip_ev(skip_ev)
);

// File: tb/blit_align_shifter_test.sv
`timescale 1ns/1ps
module blit_align_shifter_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        blit_start = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_q;
  logic        dir_neg = 0;
  logic [15:0] last_mask = 0;
  logic        step_req = 0, step_first = 0, step_last = 0;
  logic        busy, fetch_req, out_valid;
  logic        src_valid = 0;
  logic [15:0] src_data = 0;
  logic [15:0] out_word;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_hold = 0;
  int          m_skew = 0;
  bit          m_extra = 0, m_supp = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  blit_align_shifter uut (
    .clk(clk), .rst(rst), .blit_start(blit_start), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .dir_neg(dir_neg),
    .last_mask(last_mask), .step_req(step_req), .step_first(step_first),
    .step_last(step_last), .busy(busy), .fetch_req(fetch_req),
    .src_valid(src_valid), .src_data(src_data), .out_valid(out_valid),
    .out_word(out_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int model_need(bit first, bit last);
    logic [31:0] thr;
    thr = (32'hFFFF << (16 - m_skew)) & 32'hFFFF;
    if (first) return m_extra ? 2 : 1;
    if (last && m_supp && !(thr > {16'h0, last_mask})) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] next_word(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
    m_skew  = int'(v[3:0]);
    m_extra = v[7];
    m_supp  = v[6];
    check("R2 cfg_q", {24'h0, cfg_q}, {24'h0, v & 8'hCF});
  endtask

  task automatic pulse_blit;
    @(negedge clk); blit_start = 1;
    @(negedge clk); blit_start = 0;
    m_hold = 0;
  endtask

  task automatic run_step(input bit first, input bit last, input int stall, input string tag);
    int  exp_need;
    int  fetched;
    int  wait_cnt;
    int  guard;
    bit  done;
    bit  poked;
    logic [15:0] expw;
    exp_need = model_need(first, last);
    fetched = 0; wait_cnt = 0; guard = 0; done = 0; poked = 0;
    @(negedge clk); step_req = 1; step_first = first; step_last = last;
    if (exp_need == 0) m_hold = dir_neg ? (m_hold >> 16) : (m_hold << 16);
    @(negedge clk); step_req = 0;
    while (!done && guard < 100) begin
      src_valid = 0;
      if (out_valid) begin
        done = 1;
        expw = 16'((m_hold >> m_skew) & 32'hFFFF);
        check($sformatf("R3 %s word (first=%0d last=%0d skew=%0d dir=%0d)",
              tag, first, last, m_skew, dir_neg), {16'h0, out_word}, {16'h0, expw});
        check($sformatf("R7 R8 R9 %s fetch count", tag), fetched, exp_need);
      end else if (fetch_req) begin
        if (!poked && stall > 0) begin step_req = 1; poked = 1; end  // R11 ignored while busy
        if (wait_cnt >= stall) begin
          lfsr = next_word(lfsr);
          src_valid = 1; src_data = lfsr;
          m_hold = dir_neg ? ((m_hold >> 16) | ({16'h0, lfsr} << 16))
                           : ((m_hold << 16) | {16'h0, lfsr});
          fetched++; wait_cnt = 0;
        end else wait_cnt++;
      end
      guard++;
      @(negedge clk); step_req = 0;
    end
    src_valid = 0;
    if (!done) check("R10 step completion", 0, 1);
    check("R11 idle after word", {30'h0, busy, out_valid}, 32'h0);
  endtask

  task automatic spurious_src;
    @(negedge clk); src_valid = 1; src_data = 16'hDEAD;
    @(negedge clk); src_valid = 0;
    check("R10 no fetch_req while idle", {31'h0, fetch_req}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset busy", {31'h0, busy}, 32'h0);
    check("R1 reset fetch_req", {31'h0, fetch_req}, 32'h0);
    check("R1 reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 reset cfg_q", {24'h0, cfg_q}, 32'h0);
    // R1: zero-fetch step straight after reset returns 0x0000.
    write_cfg(8'h40);
    last_mask = 16'hFFFF;
    run_step(1'b0, 1'b1, 0, "R1 R6");
    write_cfg(8'hFF);
    write_cfg(8'h30);

    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 16; s++)
        for (int f = 0; f < 4; f++)
          for (int mi = 0; mi < 4; mi++)
            for (int len = 1; len <= 3; len++) begin
              write_cfg({f[1:0], 2'b11, s[3:0]});
              pulse_blit();
              dir_neg = d[0];
              case (mi)
                0: last_mask = 16'h0000;
                1: last_mask = 16'h00FF;
                2: last_mask = 16'hF000;
                default: last_mask = 16'hFFFF;
              endcase
              if (((s + mi + len) % 5) == 0) spurious_src();
              for (int w = 0; w < len; w++)
                run_step(w == 0, w == len - 1, (s + w + mi) % 3, d[0] ? "R5" : "R4");
            end

    // R12: fill, clear, then a zero-fetch tail step must return 0.
    dir_neg = 0;
    write_cfg(8'h40);
    last_mask = 16'hFFFF;
    run_step(1'b1, 1'b0, 0, "R12 fill");
    pulse_blit();
    check("R12 idle after clear", {31'h0, busy}, 32'h0);
    run_step(1'b0, 1'b1, 0, "R12 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule